// File: doc/BRIEF.md
# Register Stack Frame Renamer

This block holds a physical file of general data registers and presents it to the caller as a stack of register frames. An allocate command with a count N opens a new frame: logical registers 1 to N then name N physical registers that no live frame owns, and the previous frame drops out of view. No values are copied. The frame is switched by moving a base pointer, so the change takes one clock cycle. A pop command returns to the previous frame's mapping in one cycle, and every value that frame held is visible again.

Two read ports and one write port take signed logical register numbers. A positive number k, from 1 to the current frame size, reaches the current frame. A negative number −k reaches the calling frame. The caller's registers therefore stay reachable without being saved anywhere. A small stack keeps the base and size of every suspended frame.

The block does not spill registers to memory. It only reports an allocate that cannot fit (overflow) and a pop that has no frame to return to (underflow). Reads have one cycle of latency.

Top module: `regframe_renamer`

## Requirements
- R1: After reset the current frame size is 0 and no frames are saved. Every read or write is therefore illegal, and the overflow and underflow outputs are low.
- R2: An accepted allocate of N places the new frame directly after the current one, modulo the file size. Logical k, for 1 ≤ k ≤ N, maps to physical (old base + old size + k − 1) mod NREGS, and it is usable in the cycle after the allocate.
- R3: Allocating leaves the caller's values untouched. Logical −k, for 1 ≤ k ≤ caller size, reads or writes the caller's logical register (caller size + 1 − k), so −1 is the caller's highest register.
- R4: An accepted pop restores the previous frame's base and size in one cycle. Its values read back unchanged from the next cycle on.
- R5: An allocate is refused when the live register total plus N would exceed NREGS, or when DEPTH frames are already saved. ovf_o is then high for one cycle and the frame does not change. An allocate that brings the total to exactly NREGS is accepted.
- R6: A pop with no saved frame raises unf_o for one cycle and changes nothing.
- R7: A logical number that is 0, above the current size, or below −(caller size) is illegal. The port's illegal flag is set, an illegal read returns zero, and an illegal write changes no register.
- R8: A write issued in the same cycle as an allocate or a pop uses the mapping from before the frame change. Reads in that cycle do the same.
- R9: When allocate and pop are both asserted, the allocate is carried out and the pop is ignored.
- R10: A read of the register being written in the same cycle returns the value it held before the write.
- R11: Read data and all flags are registered. They appear in the cycle after the command or address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_i | input | 1 | Allocate a new frame |
| alloc_cnt_i | input | CW | Size N of the new frame |
| pop_i | input | 1 | Return to the previous frame |
| rd_a_lr_i | input | LW (signed) | Logical number for read port A |
| rd_b_lr_i | input | LW (signed) | Logical number for read port B |
| wr_en_i | input | 1 | Write enable |
| wr_lr_i | input | LW (signed) | Logical number for the write |
| wr_data_i | input | DW | Write data |
| rd_a_data_o | output | DW | Read port A data, one cycle latency |
| rd_b_data_o | output | DW | Read port B data, one cycle latency |
| rd_a_ill_o | output | 1 | Read A address was illegal |
| rd_b_ill_o | output | 1 | Read B address was illegal |
| wr_ill_o | output | 1 | Write address was illegal (write dropped) |
| ovf_o | output | 1 | Allocate refused |
| unf_o | output | 1 | Pop refused |

## Verification
The assertions check several rules on every cycle. The live register total never exceeds the file size, and the saved-frame count never exceeds DEPTH. An accepted allocate installs the requested size, and an accepted pop releases exactly the current frame's registers. A refused allocate or pop leaves the frame unchanged. An illegal read always returns zero, and logical 0 is always flagged. The bench's scenarios show the rest: that the data really survives frame changes, that negative numbers reach the right caller register, and that an ignored write stays out of the file. They also cover the old mapping seen by a write that coincides with a frame change, the read-before-write ordering, and the exact boundaries of the size and depth limits. A behavioural model checks each of these cycle by cycle.

// File: rtl/regframe_pkg.sv
`timescale 1ns/1ps
package regframe_pkg;
  typedef enum logic [1:0] {
    FOP_IDLE  = 2'd0,
    FOP_ALLOC = 2'd1,
    FOP_POP   = 2'd2
  } frame_op_e;
endpackage

// File: rtl/regframe_ctrl.sv
`timescale 1ns/1ps
module regframe_ctrl
  import regframe_pkg::*;
#(
  parameter int NREGS = 128,
  parameter int DEPTH = 16,
  parameter int PW    = $clog2(NREGS),
  parameter int CW    = $clog2(NREGS + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  frame_op_e     op_i,
  input  logic [CW-1:0] cnt_i,
  output logic [PW-1:0] base_o,
  output logic [CW-1:0] size_o,
  output logic [CW-1:0] prev_o,
  output logic          ovf_o,
  output logic          unf_o
);
  localparam int SPW = $clog2(DEPTH + 1);
  localparam int IW  = $clog2(DEPTH);

  logic [PW-1:0]  stk_base [DEPTH];
  logic [CW-1:0]  stk_size [DEPTH];
  logic [SPW-1:0] sp_q;
  logic [CW-1:0]  live_q;
  logic [PW-1:0]  base_q;
  logic [CW-1:0]  size_q;

  logic [CW:0]   live_sum;
  logic          full, empty, alloc_ok, pop_ok;
  logic [IW-1:0] push_idx, top_idx;

  always_comb begin
    live_sum = {1'b0, live_q} + {1'b0, cnt_i};
    full     = (sp_q == SPW'(DEPTH));
    empty    = (sp_q == '0);
    push_idx = IW'(sp_q);
    top_idx  = IW'(sp_q - 1'b1);
    alloc_ok = (op_i == FOP_ALLOC) && !full && (live_sum <= (CW+1)'(NREGS));
    pop_ok   = (op_i == FOP_POP) && !empty;
  end

  // saved-frame stack: plain RAM, no reset
  always_ff @(posedge clk) begin
    if (alloc_ok) begin
      stk_base[push_idx] <= base_q;
      stk_size[push_idx] <= size_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sp_q   <= '0;
      live_q <= '0;
      base_q <= '0;
      size_q <= '0;
      ovf_o  <= 1'b0;
      unf_o  <= 1'b0;
    end else begin
      ovf_o <= (op_i == FOP_ALLOC) && !alloc_ok;
      unf_o <= (op_i == FOP_POP) && empty;
      if (alloc_ok) begin
        sp_q   <= sp_q + 1'b1;
        base_q <= base_q + PW'(size_q);
        size_q <= cnt_i;
        live_q <= live_sum[CW-1:0];
      end else if (pop_ok) begin
        sp_q   <= sp_q - 1'b1;
        base_q <= stk_base[top_idx];
        size_q <= stk_size[top_idx];
        live_q <= live_q - size_q;
      end
    end
  end

  assign base_o = base_q;
  assign size_o = size_q;
  assign prev_o = empty ? '0 : stk_size[top_idx];

  // R5: live total bounded by file size
  p_no_overflow_r5: assert property (@(posedge clk) disable iff (rst)
    live_q <= CW'(NREGS));
  // R5: saved-frame count bounded
  p_depth_bound_r5: assert property (@(posedge clk) disable iff (rst)
    sp_q <= SPW'(DEPTH));
  // R5: refused allocate leaves the frame alone
  p_ovf_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (op_i == FOP_ALLOC && full) |=> ovf_o && $stable(sp_q) && $stable(size_q));
  // R2: accepted allocate installs requested size
  p_alloc_size_r2: assert property (@(posedge clk) disable iff (rst)
    alloc_ok |=> (size_q == $past(cnt_i)) && (sp_q == $past(sp_q) + 1'b1));
  // R4: accepted pop releases exactly the current frame
  p_pop_live_r4: assert property (@(posedge clk) disable iff (rst)
    pop_ok |=> (live_q == $past(live_q) - $past(size_q)));
  // R6: pop on empty stack changes nothing
  p_unf_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (op_i == FOP_POP && empty) |=> unf_o && $stable(base_q) && $stable(size_q) && (sp_q == '0));
endmodule

// File: rtl/regframe_xlate.sv
`timescale 1ns/1ps
module regframe_xlate #(
  parameter int PW = 7,
  parameter int CW = 8,
  parameter int LW = CW + 1
) (
  input  logic [PW-1:0]        base_i,
  input  logic [CW-1:0]        size_i,
  input  logic [CW-1:0]        prev_i,
  input  logic signed [LW-1:0] lr_i,
  output logic [PW-1:0]        phys_o,
  output logic                 legal_o
);
  logic signed [LW:0] lx, sz, pv;
  logic               pos, neg;

  always_comb begin
    lx  = {lr_i[LW-1], lr_i};
    sz  = $signed({{(LW+1-CW){1'b0}}, size_i});
    pv  = $signed({{(LW+1-CW){1'b0}}, prev_i});
    pos = (lx > 0);
    neg = lx[LW];
    legal_o = (pos && (lx <= sz)) || (neg && (-lx <= pv));
    // modulo file size by truncation; negatives land below the base
    phys_o  = base_i + lr_i[PW-1:0] - {{(PW-1){1'b0}}, pos};
  end
endmodule

// File: rtl/regframe_file.sv
`timescale 1ns/1ps
module regframe_file #(
  parameter int NREGS = 128,
  parameter int DW    = 32,
  parameter int PW    = $clog2(NREGS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we_i,
  input  logic [PW-1:0] wa_i,
  input  logic [DW-1:0] wd_i,
  input  logic [PW-1:0] ra_a_i,
  input  logic          ok_a_i,
  input  logic [PW-1:0] ra_b_i,
  input  logic          ok_b_i,
  output logic [DW-1:0] rd_a_o,
  output logic [DW-1:0] rd_b_o
);
  logic [DW-1:0] mem [NREGS];

  always_ff @(posedge clk) begin
    if (we_i) mem[wa_i] <= wd_i;
  end

  // read-first: same-cycle write is not visible
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_a_o <= '0;
      rd_b_o <= '0;
    end else begin
      rd_a_o <= ok_a_i ? mem[ra_a_i] : '0;
      rd_b_o <= ok_b_i ? mem[ra_b_i] : '0;
    end
  end
endmodule

// File: rtl/regframe_renamer.sv
`timescale 1ns/1ps
module regframe_renamer
  import regframe_pkg::*;
#(
  parameter int NREGS = 128,
  parameter int DW    = 32,
  parameter int DEPTH = 16,
  localparam int PW   = $clog2(NREGS),
  localparam int CW   = $clog2(NREGS + 1),
  localparam int LW   = CW + 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 alloc_i,
  input  logic [CW-1:0]        alloc_cnt_i,
  input  logic                 pop_i,
  input  logic signed [LW-1:0] rd_a_lr_i,
  input  logic signed [LW-1:0] rd_b_lr_i,
  input  logic                 wr_en_i,
  input  logic signed [LW-1:0] wr_lr_i,
  input  logic [DW-1:0]        wr_data_i,
  output logic [DW-1:0]        rd_a_data_o,
  output logic [DW-1:0]        rd_b_data_o,
  output logic                 rd_a_ill_o,
  output logic                 rd_b_ill_o,
  output logic                 wr_ill_o,
  output logic                 ovf_o,
  output logic                 unf_o
);
  localparam int NPORT = 3;

  frame_op_e     op;
  logic [PW-1:0] base;
  logic [CW-1:0] size, prev;

  logic signed [LW-1:0] lr_v    [NPORT];
  logic [PW-1:0]        phys_v  [NPORT];
  logic                 legal_v [NPORT];

  // R9: allocate wins over pop
  assign op = alloc_i ? FOP_ALLOC : (pop_i ? FOP_POP : FOP_IDLE);

  assign lr_v[0] = rd_a_lr_i;
  assign lr_v[1] = rd_b_lr_i;
  assign lr_v[2] = wr_lr_i;

  regframe_ctrl #(.NREGS(NREGS), .DEPTH(DEPTH), .PW(PW), .CW(CW)) ctrl_i (
    .clk(clk), .rst(rst), .op_i(op), .cnt_i(alloc_cnt_i),
    .base_o(base), .size_o(size), .prev_o(prev),
    .ovf_o(ovf_o), .unf_o(unf_o)
  );

  for (genvar g = 0; g < NPORT; g++) begin : g_xl
    regframe_xlate #(.PW(PW), .CW(CW), .LW(LW)) xl_i (
      .base_i(base), .size_i(size), .prev_i(prev),
      .lr_i(lr_v[g]), .phys_o(phys_v[g]), .legal_o(legal_v[g])
    );
  end

  regframe_file #(.NREGS(NREGS), .DW(DW), .PW(PW)) file_i (
    .clk(clk), .rst(rst),
    .we_i(wr_en_i && legal_v[2]), .wa_i(phys_v[2]), .wd_i(wr_data_i),
    .ra_a_i(phys_v[0]), .ok_a_i(legal_v[0]),
    .ra_b_i(phys_v[1]), .ok_b_i(legal_v[1]),
    .rd_a_o(rd_a_data_o), .rd_b_o(rd_b_data_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_a_ill_o <= 1'b0;
      rd_b_ill_o <= 1'b0;
      wr_ill_o   <= 1'b0;
    end else begin
      rd_a_ill_o <= !legal_v[0];
      rd_b_ill_o <= !legal_v[1];
      wr_ill_o   <= wr_en_i && !legal_v[2];
    end
  end

  // R7: illegal read returns zero on both ports
  p_ill_zero_a_r7: assert property (@(posedge clk) disable iff (rst)
    rd_a_ill_o |-> (rd_a_data_o == '0));
  p_ill_zero_b_r7: assert property (@(posedge clk) disable iff (rst)
    rd_b_ill_o |-> (rd_b_data_o == '0));
  // R7: logical 0 is never legal
  p_zero_ill_r7: assert property (@(posedge clk) disable iff (rst)
    (rd_a_lr_i == '0) |=> rd_a_ill_o);
  // R9: at most one frame error per cycle
  p_one_err_r9: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ovf_o, unf_o}));
endmodule

// File: tb/regframe_renamer_tb_top.sv
`timescale 1ns/1ps
module regframe_renamer_tb_top;
  localparam int NR = 128;
  localparam int DW = 32;
  localparam int DP = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic              alloc_i = 0, pop_i = 0, wr_en_i = 0;
  logic [7:0]        alloc_cnt_i = '0;
  logic signed [8:0] rd_a_lr_i = '0, rd_b_lr_i = '0, wr_lr_i = '0;
  logic [DW-1:0]     wr_data_i = '0;
  logic [DW-1:0]     rd_a_data_o, rd_b_data_o;
  logic              rd_a_ill_o, rd_b_ill_o, wr_ill_o, ovf_o, unf_o;

  regframe_renamer #(.NREGS(NR), .DW(DW), .DEPTH(DP)) dut_i (
    .clk(clk), .rst(rst), .alloc_i(alloc_i), .alloc_cnt_i(alloc_cnt_i),
    .pop_i(pop_i), .rd_a_lr_i(rd_a_lr_i), .rd_b_lr_i(rd_b_lr_i),
    .wr_en_i(wr_en_i), .wr_lr_i(wr_lr_i), .wr_data_i(wr_data_i),
    .rd_a_data_o(rd_a_data_o), .rd_b_data_o(rd_b_data_o),
    .rd_a_ill_o(rd_a_ill_o), .rd_b_ill_o(rd_b_ill_o), .wr_ill_o(wr_ill_o),
    .ovf_o(ovf_o), .unf_o(unf_o)
  );

  // behavioural model
  int mem_m [NR];
  bit known [NR];
  int bq[$];
  int sq[$];
  int base_m = 0, size_m = 0, live_m = 0;
  int total = 0, bad = 0, cyc = 0;
  bit done = 0;

  function automatic int prev_sz();
    return (sq.size() > 0) ? sq[$] : 0;
  endfunction

  function automatic bit legal(int l);
    if (l > 0) return l <= size_m;
    if (l < 0) return -l <= prev_sz();
    return 0;
  endfunction

  function automatic int phys(int l);
    if (l > 0) return (base_m + l - 1) % NR;
    return (bq[$] + prev_sz() + l + 2 * NR) % NR;
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 40000) begin
      total++; bad++;
      $display("FAIL R11 watchdog: actual=%0d expected=%0d", cyc, 40000);
      finish_run();
    end
  end

  task automatic step(bit al, int n, bit po, int ra, int rb,
                      bit we, int wl, int wd, string tag);
    int  e_ra, e_rb;
    bit  e_ia, e_ib, e_iw, e_ov, e_un, ka, kb;
    alloc_i = al; alloc_cnt_i = 8'(n); pop_i = po;
    rd_a_lr_i = 9'(ra); rd_b_lr_i = 9'(rb);
    wr_en_i = we; wr_lr_i = 9'(wl); wr_data_i = 32'(wd);
    // outputs from pre-change state (R8, R10)
    e_ia = !legal(ra); e_ib = !legal(rb);
    ka = e_ia || known[phys(ra)]; kb = e_ib || known[phys(rb)];
    e_ra = e_ia ? 0 : mem_m[phys(ra)];
    e_rb = e_ib ? 0 : mem_m[phys(rb)];
    e_iw = we && !legal(wl);
    if (we && legal(wl)) begin
      mem_m[phys(wl)] = wd; known[phys(wl)] = 1;
    end
    e_ov = 0; e_un = 0;
    if (al) begin
      if (live_m + n > NR || sq.size() == DP) e_ov = 1;
      else begin
        bq.push_back(base_m); sq.push_back(size_m);
        base_m = (base_m + size_m) % NR; size_m = n; live_m += n;
      end
    end else if (po) begin
      if (sq.size() == 0) e_un = 1;
      else begin
        live_m -= size_m;
        base_m = bq.pop_back(); size_m = sq.pop_back();
      end
    end
    @(posedge clk);
    @(negedge clk);
    if (ka) chk(rd_a_data_o == 32'(e_ra), tag, "read A", int'(rd_a_data_o), e_ra);
    if (kb) chk(rd_b_data_o == 32'(e_rb), tag, "read B", int'(rd_b_data_o), e_rb);
    chk(rd_a_ill_o == e_ia, "R7", "ill A", int'(rd_a_ill_o), int'(e_ia));
    chk(rd_b_ill_o == e_ib, "R7", "ill B", int'(rd_b_ill_o), int'(e_ib));
    chk(wr_ill_o == e_iw, "R7", "ill W", int'(wr_ill_o), int'(e_iw));
    chk(ovf_o == e_ov, "R5", "overflow", int'(ovf_o), int'(e_ov));
    chk(unf_o == e_un, "R6", "underflow", int'(unf_o), int'(e_un));
  endtask

  task automatic rd(int a, int b, string tag);
    step(0, 0, 0, a, b, 0, 1, 0, tag);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: outputs quiet in reset
    chk(rd_a_data_o == '0 && rd_b_data_o == '0, "R1", "reset data", int'(rd_a_data_o), 0);
    chk({rd_a_ill_o, rd_b_ill_o, wr_ill_o, ovf_o, unf_o} == 5'b0, "R1", "reset flags",
        int'({rd_a_ill_o, rd_b_ill_o, wr_ill_o, ovf_o, unf_o}), 0);
    rst = 0;
    // R1: empty frame, everything illegal
    step(0, 0, 0, 1, -1, 1, 1, 5, "R1");
    step(0, 0, 1, 0, 2, 0, 1, 0, "R6");
    // R2: one full-size frame, fill the whole file
    step(1, NR, 0, 1, 0, 0, 1, 0, "R2");
    for (int i = 1; i <= NR; i++) step(0, 0, 0, i, i - 1, 1, i, 1000 + i, "R10");
    for (int i = 1; i <= NR; i += 2) rd(i, i + 1, "R2");
    step(1, 1, 0, NR, NR + 1, 0, 1, 0, "R5");
    step(1, 0, 0, 1, 0, 0, 1, 0, "R5");
    step(0, 0, 1, 1, -1, 0, 1, 0, "R4");
    step(0, 0, 1, 1, 0, 0, 1, 0, "R4");
    step(0, 0, 1, 1, 0, 0, 1, 0, "R6");
    // R2/R3/R8 nested frames
    step(1, 8, 0, 1, 0, 0, 1, 0, "R2");
    for (int i = 1; i <= 8; i++) step(0, 0, 0, i, -1, 1, i, 200 + i, "R2");
    step(1, 4, 0, 1, 8, 1, 8, 77, "R8");
    for (int k = 1; k <= 8; k += 2) rd(-k, -k - 1, "R3");
    rd(-9, 5, "R7");
    rd(0, 4, "R7");
    step(0, 0, 0, 1, 2, 1, 5, 999, "R7");
    step(0, 0, 0, 1, 2, 1, -9, 998, "R7");
    for (int i = 1; i <= 4; i++) step(0, 0, 0, i, -i, 1, i, 300 + i, "R3");
    step(0, 0, 0, -1, 1, 1, -1, 55, "R3");
    step(1, 2, 1, 1, -4, 0, 1, 0, "R9");
    rd(1, 2, "R9");
    rd(3, -2, "R9");
    step(0, 0, 1, 1, -1, 1, 2, 66, "R8");
    for (int i = 1; i <= 4; i++) rd(i, -i, "R4");
    step(0, 0, 1, 1, 2, 0, 1, 0, "R4");
    for (int i = 1; i <= 8; i += 2) rd(i, i + 1, "R4");
    step(1, 8, 0, 1, 0, 0, 1, 0, "R2");
    rd(5, 4, "R7");
    step(0, 0, 1, 0, 0, 0, 1, 0, "R4");
    step(0, 0, 1, 0, 0, 0, 1, 0, "R4");
    // R5 depth limit
    for (int i = 0; i < DP; i++) step(1, 1, 0, 1, -1, 1, 1, 500 + i, "R5");
    step(1, 1, 0, 1, -1, 0, 1, 0, "R5");
    for (int i = 0; i < DP; i++) step(0, 0, 1, 1, -1, 0, 1, 0, "R4");
    step(0, 0, 1, 1, 0, 0, 1, 0, "R6");
    // R11 mixed traffic compared every cycle
    for (int t = 0; t < 800; t++) begin
      int r = $urandom_range(0, 11);
      step(r < 2 || r == 4, $urandom_range(0, 30), r >= 2 && r <= 4,
           int'($urandom_range(0, 60)) - 30, int'($urandom_range(0, 60)) - 30,
           r > 5, int'($urandom_range(0, 60)) - 30, int'($urandom_range(0, 100000)), "R11");
    end
    finish_run();
  end
endmodule